// File: doc/BRIEF.md
# Symmetric Dual-Slope PWM Timer

This block is a 16-bit up/down timer that drives two centre-aligned PWM pins. The counter climbs from zero to a TOP value, stays there for one enabled step, and then descends back to zero, so each period is symmetric around TOP. TOP is chosen by a waveform-mode field. It can be one of three fixed widths (8, 9 or 10 bits), the value in a capture register, or the active channel-A compare value. The counter only moves on clock cycles where the count-enable tick is high. This lets an external divider set the rate.

Each channel compares its active threshold against the counter. The pin falls on an up-slope match and rises on a down-slope match, or the reverse when the channel is inverted. Software writes compare values into shadow registers, and these reach the active thresholds only at the TOP step. A write in mid-period therefore never produces a runt pulse. The block also keeps sticky flags for a match on each channel, for TOP, and for BOTTOM. Software clears a flag by writing a 1 to it through the same simple write port.

Top module: `pwm_dual_slope`

## Requirements
- R1: On each tick the counter moves one step toward the current end of its slope. On the tick where it is counting up and the count is at or above TOP, it reverses, so TOP is held for exactly one tick. On the tick where it is counting down and the count is 0, it turns upward.
- R2: Write address 0, bits [3:0], hold the waveform mode, which sets TOP. Code 1 gives 0x00FF, code 2 gives 0x01FF and code 3 gives 0x03FF. Code 10 uses the capture register and code 11 uses the active channel-A threshold. Any other code falls back to 0x00FF. The mode resets to 1.
- R3: With the tick low, the counter, the pins and the flags do not change.
- R4: Write address 1 holds the output modes: bits [1:0] for channel A and bits [3:2] for channel B. With output mode 2, a match on an up tick drives the pin low and a match on a down tick drives it high.
- R5: Output mode 3 inverts this: a match on an up tick drives the pin high and a match on a down tick drives it low.
- R6: Output modes 0 and 1 hold the pin low.
- R7: Writes to address 2 (channel A) and address 3 (channel B) load shadow registers only. The active thresholds take the shadow values at the clock edge of the TOP tick. Events on the TOP tick itself use the old thresholds.
- R8: A tick on which the count equals a channel's active threshold sets that channel's match flag.
- R9: On the TOP tick, the capture flag sets in mode 10 and the channel-A match flag sets in mode 11. Address 4 holds the capture register.
- R10: The overflow flag sets at the edge of the tick on which the counter turns upward at 0.
- R11: Writing address 5 clears the flags marked with 1: bit 0 is the A match flag, bit 1 the B match flag, bit 2 the capture flag and bit 3 the overflow flag. Unmarked flags are unaffected, and a flag being set in the same cycle wins.
- R12: While reset is low, the count is 0, the direction is up, the pins are low, the flags are clear and the active thresholds are 0.
- R13: All events are decided from the counter value before the tick and appear on the outputs after that tick's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one clock wide per step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |
| flag_cmp_a | output | 1 | Channel A match flag |
| flag_cmp_b | output | 1 | Channel B match flag |
| flag_cap | output | 1 | TOP flag when the capture register sets TOP |
| flag_ovf | output | 1 | BOTTOM flag |

## Verification
The bound checker checks the following on every cycle:
- the count holds while the tick is low;
- the count steps by one on the up slope below TOP;
- the overflow and capture flags follow their turning points;
- the active channel-A threshold changes only at the TOP step;
- a pin rises only after a tick or a register write.

Only the bench scenarios can show the other behaviours:
- the full pin sequence across periods for the non-inverted and inverted outputs;
- the exact period length for every TOP source, including the fallback code;
- the delayed take-up of a compare value written in mid-period;
- the selective flag clearing.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [3:0] WM_FIX8  = 4'd1;
  localparam logic [3:0] WM_FIX9  = 4'd2;
  localparam logic [3:0] WM_FIX10 = 4'd3;
  localparam logic [3:0] WM_CAP   = 4'd10;
  localparam logic [3:0] WM_CMPA  = 4'd11;

  typedef enum logic [2:0] {
    RA_MODE   = 3'd0,
    RA_OUTCFG = 3'd1,
    RA_CMPA   = 3'd2,
    RA_CMPB   = 3'd3,
    RA_CAP    = 3'd4,
    RA_FCLR   = 3'd5
  } reg_addr_e;

  localparam int FL_A   = 0;
  localparam int FL_B   = 1;
  localparam int FL_CAP = 2;
  localparam int FL_OVF = 3;
  localparam int NFLAGS = 4;
endpackage

// File: rtl/pwm_top_sel.sv
module pwm_top_sel #(
  parameter int W = 16
) (
  input  logic [3:0]   mode,
  input  logic [W-1:0] cap_val,
  input  logic [W-1:0] thr_a,
  output logic [W-1:0] top_val
);
  import pwm_pkg::*;

  localparam logic [W-1:0] TOP8  = W'((1 << 8) - 1);
  localparam logic [W-1:0] TOP9  = W'((1 << 9) - 1);
  localparam logic [W-1:0] TOP10 = W'((1 << 10) - 1);

  always_comb begin
    case (mode)
      WM_FIX9:  top_val = TOP9;
      WM_FIX10: top_val = TOP10;
      WM_CAP:   top_val = cap_val;
      WM_CMPA:  top_val = thr_a;
      default:  top_val = TOP8;
    endcase
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt_q,
  output logic         dir_up_q,
  output logic         at_top,
  output logic         at_bot
);
  logic [W-1:0] cnt_n;
  logic         dir_n;

  assign at_top = dir_up_q && (cnt_q >= top_val);
  assign at_bot = !dir_up_q && (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_up_q;
    if (tick) begin
      if (at_top) begin
        dir_n = 1'b0;
        cnt_n = (cnt_q == '0) ? '0 : cnt_q - W'(1);
      end else if (at_bot) begin
        dir_n = 1'b1;
        cnt_n = W'(1);
      end else if (dir_up_q) begin
        cnt_n = cnt_q + W'(1);
      end else begin
        cnt_n = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else if (tick) begin
      cnt_q    <= cnt_n;
      dir_up_q <= dir_n;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         shadow_we,
  input  logic [W-1:0] shadow_d,
  input  logic [1:0]   out_mode,
  input  logic [W-1:0] cnt,
  input  logic         dir_up,
  input  logic         at_top,
  output logic [W-1:0] thr_q,
  output logic         match,
  output logic         pin
);
  logic [W-1:0] shadow_q;
  logic         level_q;
  logic         level_n;
  logic         load_en;
  logic         level_en;

  assign match    = tick && (cnt == thr_q);
  assign load_en  = tick && at_top;
  assign level_en = match && out_mode[1];
  assign level_n  = (~dir_up) ^ out_mode[0];
  assign pin      = out_mode[1] & level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else if (shadow_we) shadow_q <= shadow_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else if (load_en) thr_q <= shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else if (level_en) level_q <= level_n;
  end
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [15:0]  wr_data,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         flag_cmp_a,
  output logic         flag_cmp_b,
  output logic         flag_cap,
  output logic         flag_ovf
);
  import pwm_pkg::*;

  localparam int NCH = 2;

  logic [3:0]        mode_q;
  logic [2*NCH-1:0]  outcfg_q;
  logic [W-1:0]      cap_q;
  logic [NFLAGS-1:0] flag_q;
  logic [NFLAGS-1:0] flag_set;
  logic [NFLAGS-1:0] flag_clr;
  logic [NFLAGS-1:0] flag_n;
  logic [W-1:0]      top_val;
  logic [W-1:0]      cnt_q;
  logic              dir_up;
  logic              at_top;
  logic              at_bot;
  logic [W-1:0]      ocr_act [NCH];
  logic [NCH-1:0]    ch_match;
  logic [NCH-1:0]    ch_pin;
  logic [NCH-1:0]    ch_we;

  logic wr_mode;
  logic wr_outcfg;
  logic wr_cap;
  logic wr_fclr;

  assign wr_mode   = wr_en && (wr_addr == RA_MODE);
  assign wr_outcfg = wr_en && (wr_addr == RA_OUTCFG);
  assign wr_cap    = wr_en && (wr_addr == RA_CAP);
  assign wr_fclr   = wr_en && (wr_addr == RA_FCLR);
  assign ch_we[0]  = wr_en && (wr_addr == RA_CMPA);
  assign ch_we[1]  = wr_en && (wr_addr == RA_CMPB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= WM_FIX8;
    else if (wr_mode) mode_q <= wr_data[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outcfg_q <= '0;
    else if (wr_outcfg) outcfg_q <= wr_data[2*NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (wr_cap) cap_q <= W'(wr_data);
  end

  pwm_top_sel #(.W(W)) i_top_sel (
    .mode    (mode_q),
    .cap_val (cap_q),
    .thr_a   (ocr_act[0]),
    .top_val (top_val)
  );

  pwm_counter #(.W(W)) i_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .top_val  (top_val),
    .cnt_q    (cnt_q),
    .dir_up_q (dir_up),
    .at_top   (at_top),
    .at_bot   (at_bot)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_channel #(.W(W)) i_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .shadow_we (ch_we[c]),
      .shadow_d  (W'(wr_data)),
      .out_mode  (outcfg_q[2*c +: 2]),
      .cnt       (cnt_q),
      .dir_up    (dir_up),
      .at_top    (at_top),
      .thr_q     (ocr_act[c]),
      .match     (ch_match[c]),
      .pin       (ch_pin[c])
    );
  end

  always_comb begin
    flag_set         = '0;
    flag_set[FL_A]   = ch_match[0] || (tick && at_top && (mode_q == WM_CMPA));
    flag_set[FL_B]   = ch_match[1];
    flag_set[FL_CAP] = tick && at_top && (mode_q == WM_CAP);
    flag_set[FL_OVF] = tick && at_bot;
    flag_clr         = wr_fclr ? wr_data[NFLAGS-1:0] : '0;
    flag_n           = (flag_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else flag_q <= flag_n;
  end

  assign pwm_a      = ch_pin[0];
  assign pwm_b      = ch_pin[1];
  assign flag_cmp_a = flag_q[FL_A];
  assign flag_cmp_b = flag_q[FL_B];
  assign flag_cap   = flag_q[FL_CAP];
  assign flag_ovf   = flag_q[FL_OVF];
endmodule

// File: rtl/pwm_dual_slope_chk.sv
module pwm_dual_slope_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_en,
  input logic [W-1:0] cnt,
  input logic         dir_up,
  input logic [W-1:0] top,
  input logic [3:0]   mode,
  input logic [W-1:0] thr_a,
  input logic         pwm_a,
  input logic         flag_ovf,
  input logic         flag_cap
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R3

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir_up && (cnt < top)) |=> (cnt == W'($past(cnt) + W'(1)))); // R1

  AST_OVF_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dir_up && (cnt == '0)) |=> flag_ovf); // R10

  AST_CAP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir_up && (cnt >= top) && (mode == 4'd10)) |=> flag_cap); // R9

  AST_THR_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && dir_up && (cnt >= top)) |=> $stable(thr_a)); // R7

  AST_PIN_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_a) |-> ($past(tick) || $past(wr_en))); // R13
endmodule

bind pwm_dual_slope pwm_dual_slope_chk #(.W(W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .wr_en    (wr_en),
  .cnt      (cnt_q),
  .dir_up   (dir_up),
  .top      (top_val),
  .mode     (mode_q),
  .thr_a    (ocr_act[0]),
  .pwm_a    (pwm_a),
  .flag_ovf (flag_ovf),
  .flag_cap (flag_cap)
);

// File: tb/test_pwm_dual_slope.sv
`timescale 1ns/1ps
module test_pwm_dual_slope;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        pwm_a, pwm_b;
  logic        flag_cmp_a, flag_cmp_b, flag_cap, flag_ovf;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // expected {pwm_a, pwm_b} after ticks 1..16, mode 10, cap 5, A=2 noninv, B=4 inv
  localparam logic [1:0] EXP_AB [16] = '{
    2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,
    2'b00, 2'b00, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b00, 2'b00, 2'b01, 2'b01
  };

  always #2.5 clk = ~clk;

  pwm_dual_slope i_pwm_dual_slope (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .flag_cmp_a(flag_cmp_a),
    .flag_cmp_b(flag_cmp_b), .flag_cap(flag_cap), .flag_ovf(flag_ovf)
  );

  function automatic logic [3:0] flags();
    return {flag_ovf, flag_cap, flag_cmp_b, flag_cmp_a};
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({14'd0, pwm_a, pwm_b}, 16'd0, "R12 pins in reset");
    chk({12'd0, flags()}, 16'd0, "R12 flags in reset");
    rst_n = 1'b1;

    // vector run: mode 10, capture TOP 5 (R2, R4, R5, R1)
    wr(3'd0, 16'd10);
    wr(3'd1, 16'b1110);
    wr(3'd2, 16'd2);
    wr(3'd3, 16'd4);
    wr(3'd4, 16'd5);
    chk({14'd0, pwm_a, pwm_b}, 16'd0, "R7 writes alone move no pin");
    for (int k = 0; k < 16; k++) begin
      step();
      chk({14'd0, pwm_a, pwm_b}, {14'd0, EXP_AB[k]}, $sformatf("R4 R5 R1 tick %0d", k + 1));
    end
    // R8 R9 R10 all flags set by now
    chk({12'd0, flags()}, 16'hF, "R8 R9 R10 flags after two TOPs");
    // R11 clear A and overflow only
    wr(3'd5, 16'b1001);
    chk({12'd0, flags()}, 16'b0110, "R11 selective clear");

    // R7 mid-period write of A shadow: old threshold governs until TOP
    wr(3'd2, 16'd4);
    steps(3);
    chk({15'd0, pwm_a}, 16'd1, "R7 old threshold on down slope");
    chk({15'd0, pwm_b}, 16'd0, "R5 inverted clears on down match");
    steps(4);
    chk({15'd0, pwm_a}, 16'd0, "R7 old threshold on up slope");
    steps(4);
    chk({15'd0, pwm_a}, 16'd1, "R7 new threshold after TOP");

    // R3 idle cycles move nothing
    repeat (5) @(negedge clk);
    chk({14'd0, pwm_a, pwm_b}, 16'b10, "R3 pins hold without tick");

    // R6 disconnected output modes
    wr(3'd1, 16'b1100);
    chk({15'd0, pwm_a}, 16'd0, "R6 mode 0 pin low");
    wr(3'd1, 16'b1101);
    chk({15'd0, pwm_a}, 16'd0, "R6 mode 1 pin low");

    // R12 asynchronous reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk({10'd0, pwm_a, pwm_b, flags()}, 16'd0, "R12 reset mid-run");
    @(negedge clk) rst_n = 1'b1;

    // R2 fixed TOP modes: overflow after 2*TOP+1 ticks; R3 with gaps in mode 1
    for (int m = 0; m < 4; m++) begin
      int tp;
      logic [3:0] code;
      code = (m == 0) ? 4'd1 : (m == 1) ? 4'd2 : (m == 2) ? 4'd3 : 4'd6;
      tp   = (m == 1) ? 511 : (m == 2) ? 1023 : 255;
      do_reset();
      wr(3'd0, {12'd0, code});
      for (int i = 0; i < 2 * tp; i++) begin
        step();
        if (m == 0) @(negedge clk);
      end
      chk({15'd0, flag_ovf}, 16'd0, $sformatf("R2 code %0d no BOTTOM yet", code));
      step();
      chk({15'd0, flag_ovf}, 16'd1, $sformatf("R2 R10 code %0d BOTTOM", code));
      chk({15'd0, flag_cap}, 16'd0, $sformatf("R9 code %0d no capture flag", code));
    end

    // R2 R9 mode 11: TOP from active A threshold
    do_reset();
    wr(3'd0, 16'd11);
    wr(3'd1, 16'b0010);
    wr(3'd2, 16'd3);
    steps(2);
    chk({15'd0, flag_ovf}, 16'd1, "R2 mode 11 first BOTTOM");
    wr(3'd5, 16'hF);
    chk({12'd0, flags()}, 16'd0, "R11 clear all");
    steps(2);
    chk({15'd0, flag_cmp_a}, 16'd0, "R9 no A flag before TOP");
    step();
    chk({15'd0, flag_cmp_a}, 16'd1, "R9 A flag at TOP in mode 11");
    chk({15'd0, flag_cap}, 16'd0, "R9 no capture flag in mode 11");
    steps(2);
    chk({15'd0, flag_ovf}, 16'd0, "R1 mode 11 descending");
    step();
    chk({15'd0, flag_ovf}, 16'd1, "R1 R10 mode 11 BOTTOM after TOP 3");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule